// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit register datapath and a data memory that is organized as 32-bit words but addressed by byte. For each request it forms the effective byte address from a base register value and a signed 16-bit offset. It then drives a word-aligned memory address. For stores it also drives a per-lane write-enable mask and write data copied onto every lane, so the memory keeps only the lanes that are enabled.

For loads, the unit remembers which lane or lane pair was addressed. When the memory word comes back, it picks out the byte, halfword or word. It then widens the result to 32 bits with zeros or with copies of its top bit, as the request asks. Halfword accesses on odd addresses, word accesses off a four-byte boundary and the reserved size code are reported as faults. A faulting request writes nothing and reads nothing.

The memory request appears one clock after the request is sampled. The memory answers in the same cycle, and the widened load result appears one clock after that.

Top module: `lsa_unit`

## Requirements
- R1: The effective address is `baseAddr` plus `offset` sign-extended to 32 bits. One cycle after a request, `memAddr` equals that address with bits 1:0 forced to 0.
- R2: `reqOp[1:0]` selects the size: 00 byte, 01 halfword, 10 word, 11 reserved. `reqOp[2]`=1 requests zero extension on loads, and 0 requests sign extension. Lanes are little-endian: lane k is bits 8k+7:8k of the memory word and is addressed by effective-address bits 1:0 equal to k.
- R3: A byte store drives `memWe` = 0001 shifted left by EA[1:0], and drives `memWdata` = the low 8 bits of `storeData` copied into all four lanes.
- R4: A halfword store with EA[0]=0 drives `memWe` = 0011 when EA[1]=0 and 1100 when EA[1]=1, with the low 16 bits of `storeData` copied into both halves.
- R5: A word store with EA[1:0]=00 drives `memWe`=1111 and `memWdata`=`storeData`.
- R6: A byte load returns the addressed lane in bits 7:0. The upper 24 bits are zeros when `reqOp[2]`=1, and copies of lane bit 7 otherwise.
- R7: A halfword load returns lane pair EA[1] in bits 15:0. The upper 16 bits are zeros when `reqOp[2]`=1, and copies of bit 15 otherwise.
- R8: A word load returns the whole memory word, whatever the value of `reqOp[2]`.
- R9: A halfword with EA[0]=1, a word with EA[1:0]≠00, or size code 11 raises `accErr` one cycle after the request. In that cycle `memWe`=0000 and `memRd`=0, and no `loadValid` follows.
- R10: `memWe`, `memWdata` and `memRd` reflect the request one cycle after it is sampled. `loadValid` and `loadData` follow one cycle after `memRd`. A cycle with `reqValid`=0 yields `memWe`=0000, `memRd`=0 and `accErr`=0.
- R11: While `rstN` is low, `memWe`, `memRd`, `accErr`, `loadValid`, `memAddr`, `memWdata` and `loadData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqStore | input | 1 | 1 for a store, 0 for a load |
| reqOp | input | 3 | Size in bits 1:0, zero-extend flag in bit 2 |
| baseAddr | input | 32 | Base register value |
| offset | input | 16 | Signed byte offset |
| storeData | input | 32 | Register value to store |
| memRdata | input | 32 | Word returned by memory for `memAddr` in the same cycle |
| memAddr | output | 32 | Word-aligned byte address |
| memWe | output | 4 | Per-lane write enables |
| memWdata | output | 32 | Store data copied across lanes |
| memRd | output | 1 | Load read strobe |
| accErr | output | 1 | Misaligned or reserved-size fault |
| loadValid | output | 1 | `loadData` holds a new result |
| loadData | output | 32 | Extended load result |

## Verification
The assertions assume that the memory returns, in the same cycle, the word for the presented `memAddr`. They also assume that `reqOp` and `reqStore` are stable for the whole cycle in which `reqValid` is high. The bench keeps to this with a combinational memory model, and it changes request inputs only on the falling clock edge. Its addresses stay inside the model's sixteen words, and the negative offsets it uses do not wrap below address zero. The request mix covers every lane position, both extension modes, all three sizes, each fault kind and idle cycles between requests.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int LSA_LANES = 4;
  localparam int LSA_SEL_W = $clog2(LSA_LANES);
  localparam int LSA_DATA_W = LSA_LANES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } accSize_e;

  typedef struct packed {
    logic                 doStore;
    logic                 doLoad;
    logic                 fault;
    accSize_e             size;
    logic                 zeroExt;
    logic [LSA_SEL_W-1:0] laneSel;
    logic [LSA_LANES-1:0] laneMask;
  } lsaStrobe_t;
endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] effAddr,
  output lsaStrobe_t        strobe
);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [LSA_LANES-1:0] ONE_LANE  = LSA_LANES'(1);
  localparam logic [LSA_LANES-1:0] TWO_LANES = LSA_LANES'(3);

  accSize_e             sizeSel;
  logic [LSA_SEL_W-1:0] sel;
  logic [LSA_SEL_W-1:0] halfBase;
  logic [LSA_LANES-1:0] rawMask;
  logic                 misaligned;

  assign effAddr  = baseAddr + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign sel      = effAddr[LSA_SEL_W-1:0];
  assign halfBase = {sel[LSA_SEL_W-1:1], 1'b0};
  assign sizeSel  = accSize_e'(reqOp[1:0]);

  always_comb begin
    rawMask    = '0;
    misaligned = 1'b0;
    unique case (sizeSel)
      SZ_BYTE: rawMask = ONE_LANE << sel;
      SZ_HALF: begin
        rawMask    = TWO_LANES << halfBase;
        misaligned = sel[0];
      end
      SZ_WORD: begin
        rawMask    = '1;
        misaligned = |sel;
      end
      default: misaligned = 1'b1;
    endcase
  end

  always_comb begin
    strobe.doStore  = reqValid & reqStore & ~misaligned;
    strobe.doLoad   = reqValid & ~reqStore & ~misaligned;
    strobe.fault    = reqValid & misaligned;
    strobe.size     = sizeSel;
    strobe.zeroExt  = reqOp[2];
    strobe.laneSel  = sel;
    strobe.laneMask = (reqValid & reqStore & ~misaligned) ? rawMask : '0;
  end
endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lsaStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     effAddr,
  input  logic [LSA_DATA_W-1:0] storeData,
  input  logic [LSA_DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LSA_LANES-1:0]  memWe,
  output logic [LSA_DATA_W-1:0] memWdata,
  output logic                  memRd,
  output logic                  accErr,
  output logic                  loadValid,
  output logic [LSA_DATA_W-1:0] loadData
);
  localparam int HALVES = LSA_LANES / 2;
  localparam int BYTE_PAD = LSA_DATA_W - 8;
  localparam int HALF_PAD = LSA_DATA_W - 16;

  logic [LSA_DATA_W-1:0] byteRep, halfRep, wdataNext, extData;
  logic [7:0]            laneBytes [LSA_LANES];
  logic [15:0]           laneHalves[HALVES];
  logic [7:0]            pickByte;
  logic [15:0]           pickHalf;
  accSize_e              ldSize;
  logic [LSA_SEL_W-1:0]  ldSel;
  logic                  ldZero;

  for (genvar l = 0; l < LSA_LANES; l++) begin : g_lane
    assign byteRep[l*8 +: 8] = storeData[7:0];
    assign laneBytes[l]      = memRdata[l*8 +: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign halfRep[h*16 +: 16] = storeData[15:0];
    assign laneHalves[h]       = memRdata[h*16 +: 16];
  end

  always_comb begin
    unique case (strobe.size)
      SZ_BYTE: wdataNext = byteRep;
      SZ_HALF: wdataNext = halfRep;
      default: wdataNext = storeData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memWe    <= '0;
      memWdata <= '0;
      memRd    <= 1'b0;
      accErr   <= 1'b0;
      ldSize   <= SZ_WORD;
      ldSel    <= '0;
      ldZero   <= 1'b0;
    end else begin
      memAddr  <= {effAddr[ADDR_W-1:LSA_SEL_W], {LSA_SEL_W{1'b0}}};
      memWe    <= strobe.laneMask;
      memWdata <= strobe.doStore ? wdataNext : '0;
      memRd    <= strobe.doLoad;
      accErr   <= strobe.fault;
      ldSize   <= strobe.size;
      ldSel    <= strobe.laneSel;
      ldZero   <= strobe.zeroExt;
    end
  end

  assign pickByte = laneBytes[ldSel];
  assign pickHalf = laneHalves[ldSel[LSA_SEL_W-1:1]];

  always_comb begin
    unique case (ldSize)
      SZ_BYTE: extData = {{BYTE_PAD{~ldZero & pickByte[7]}}, pickByte};
      SZ_HALF: extData = {{HALF_PAD{~ldZero & pickHalf[15]}}, pickHalf};
      default: extData = memRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      loadData  <= '0;
    end else begin
      loadValid <= memRd;
      if (memRd) loadData <= extData;
    end
  end

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (memWe == '0 && !memRd)); // R9
  AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(memWe) == 0 || $countones(memWe) == 1 ||
     $countones(memWe) == 2 || $countones(memWe) == LSA_LANES)); // R3
  AST_READ_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memWe == '0)); // R10
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(memRd)); // R10
  AST_FAULT_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    accErr |=> !loadValid); // R9
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqStore,
  input  logic [2:0]            reqOp,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [OFF_W-1:0]      offset,
  input  logic [LSA_DATA_W-1:0] storeData,
  input  logic [LSA_DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LSA_LANES-1:0]  memWe,
  output logic [LSA_DATA_W-1:0] memWdata,
  output logic                  memRd,
  output logic                  accErr,
  output logic                  loadValid,
  output logic [LSA_DATA_W-1:0] loadData
);
  lsaStrobe_t        strobe;
  logic [ADDR_W-1:0] effAddr;

  lsa_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .reqValid (reqValid),
    .reqStore (reqStore),
    .reqOp    (reqOp),
    .baseAddr (baseAddr),
    .offset   (offset),
    .effAddr  (effAddr),
    .strobe   (strobe)
  );

  lsa_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .effAddr   (effAddr),
    .storeData (storeData),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .memRd     (memRd),
    .accErr    (accErr),
    .loadValid (loadValid),
    .loadData  (loadData)
  );
endmodule

// File: tb/lsa_unit_tb.sv
module lsa_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [31:0] baseAddr = '0, storeData = '0;
  logic [15:0] offset = '0;
  logic [31:0] memRdata, memAddr, memWdata, loadData;
  logic [3:0]  memWe;
  logic        memRd, accErr, loadValid;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  we;
    logic [31:0] wdata;
    logic        rd;
    logic        err;
    logic        chkAddr;
    logic [31:0] ldData;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] memArr[16];
  logic [31:0] shadow[16];
  logic        pendLd = 1'b0;
  logic [31:0] pendData = '0;
  string       pendTag = "";
  bit          active = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsa_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqOp(reqOp), .baseAddr(baseAddr), .offset(offset),
    .storeData(storeData), .memRdata(memRdata), .memAddr(memAddr),
    .memWe(memWe), .memWdata(memWdata), .memRd(memRd), .accErr(accErr),
    .loadValid(loadValid), .loadData(loadData)
  );

  function automatic logic [31:0] seedWord(int i);
    return (32'h1111_1111 * i) ^ 32'h80F0_7F0F;
  endfunction

  // memory model: combinational read, lane-masked write
  assign memRdata = memArr[memAddr[5:2]];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) memArr[i] <= seedWord(i);
    end else begin
      for (int l = 0; l < 4; l++)
        if (memWe[l]) memArr[memAddr[5:2]][l*8 +: 8] <= memWdata[l*8 +: 8];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: sample 2 time units after the rising edge
  always @(posedge clk) begin
    #2;
    if (active) begin
      check({pendTag, " loadValid"}, {31'b0, loadValid}, {31'b0, pendLd});
      if (pendLd) check({pendTag, " loadData"}, loadData, pendData);
      pendLd = 1'b0;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " memWe"}, {28'b0, memWe}, {28'b0, e.we});
        check({e.tag, " memRd"}, {31'b0, memRd}, {31'b0, e.rd});
        check({e.tag, " accErr"}, {31'b0, accErr}, {31'b0, e.err});
        if (e.chkAddr) check({e.tag, " memAddr"}, memAddr, e.addr);
        if (e.we != 4'b0) check({e.tag, " memWdata"}, memWdata, e.wdata);
        pendLd   = e.rd;
        pendData = e.ldData;
        pendTag  = e.tag;
      end
    end
  end

  task automatic doReq(bit st, logic [2:0] op, logic [31:0] base,
                       logic [15:0] off, logic [31:0] data, string tag);
    exp_t e;
    logic [31:0] ea, w;
    logic [1:0]  sel;
    logic        mis;
    logic [3:0]  mask;
    logic [31:0] wd;
    logic [7:0]  b;
    logic [15:0] h;
    @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqOp = op;
    baseAddr = base; offset = off; storeData = data;
    ea  = base + {{16{off[15]}}, off};
    sel = ea[1:0];
    mis = (op[1:0] == 2'b11) || (op[1:0] == 2'b01 && sel[0]) ||
          (op[1:0] == 2'b10 && sel != 2'b00);
    case (op[1:0])
      2'b00:   begin mask = 4'b0001 << sel; wd = {4{data[7:0]}}; end
      2'b01:   begin mask = sel[1] ? 4'b1100 : 4'b0011; wd = {2{data[15:0]}}; end
      default: begin mask = 4'b1111; wd = data; end
    endcase
    e.addr = {ea[31:2], 2'b00};
    e.chkAddr = 1'b1;
    e.we = (st && !mis) ? mask : 4'b0;
    e.wdata = wd;
    e.rd = !st && !mis;
    e.err = mis;
    e.tag = tag;
    e.ldData = '0;
    if (st && !mis)
      for (int l = 0; l < 4; l++)
        if (mask[l]) shadow[ea[5:2]][l*8 +: 8] = wd[l*8 +: 8];
    if (!st && !mis) begin
      w = shadow[ea[5:2]];
      b = w[sel*8 +: 8];
      h = sel[1] ? w[31:16] : w[15:0];
      case (op[1:0])
        2'b00:   e.ldData = op[2] ? {24'b0, b} : {{24{b[7]}}, b};
        2'b01:   e.ldData = op[2] ? {16'b0, h} : {{16{h[15]}}, h};
        default: e.ldData = w;
      endcase
    end
    expQ.push_back(e);
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b0;
    reqStore = 1'b1;
    e.addr = '0; e.chkAddr = 1'b0; e.we = '0; e.wdata = '0;
    e.rd = 1'b0; e.err = 1'b0; e.ldData = '0; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = seedWord(i);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 memWe", {28'b0, memWe}, 32'h0);
    check("R11 memRd", {31'b0, memRd}, 32'h0);
    check("R11 accErr", {31'b0, accErr}, 32'h0);
    check("R11 loadValid", {31'b0, loadValid}, 32'h0);
    check("R11 memAddr", memAddr, 32'h0);
    check("R11 memWdata", memWdata, 32'h0);
    check("R11 loadData", loadData, 32'h0);
    rstN = 1'b1;
    active = 1;
    // R5 word store, R1 with positive offset
    doReq(1, 3'b010, 32'h0000_0010, 16'h0004, 32'h8A5B_C3F1, "R5 sw");
    // R8 word loads, both extension flags
    doReq(0, 3'b010, 32'h0000_0014, 16'h0000, 32'h0, "R8 lw");
    doReq(0, 3'b110, 32'h0000_0014, 16'h0000, 32'h0, "R8 lw-u");
    // R3 byte stores in every lane
    for (int k = 0; k < 4; k++)
      doReq(1, 3'b000, 32'h0000_0020, 16'(k), 32'h1234_56E0 + 32'(k*9), "R3 sb");
    // R6 byte loads in every lane, signed and unsigned
    for (int k = 0; k < 4; k++) begin
      doReq(0, 3'b000, 32'h0000_0020, 16'(k), 32'h0, "R6 lb");
      doReq(0, 3'b100, 32'h0000_0020, 16'(k), 32'h0, "R6 lbu");
    end
    // R2 lane order on seeded word (mixed sign bits)
    for (int k = 0; k < 4; k++) doReq(0, 3'b000, 32'h0000_0008, 16'(k), 32'h0, "R2 lb seed");
    // R4 halfword stores, both halves
    doReq(1, 3'b001, 32'h0000_0030, 16'h0000, 32'hFFFF_7A81, "R4 sh lo");
    doReq(1, 3'b001, 32'h0000_0030, 16'h0002, 32'h0000_9C3E, "R4 sh hi");
    // R7 halfword loads
    doReq(0, 3'b001, 32'h0000_0030, 16'h0000, 32'h0, "R7 lh lo");
    doReq(0, 3'b001, 32'h0000_0030, 16'h0002, 32'h0, "R7 lh hi");
    doReq(0, 3'b101, 32'h0000_0030, 16'h0002, 32'h0, "R7 lhu hi");
    doReq(0, 3'b101, 32'h0000_0030, 16'h0000, 32'h0, "R7 lhu lo");
    // R10 idle cycles between requests
    idle("R10 idle");
    idle("R10 idle");
    // R9 faults: odd halfword, unaligned word, reserved size
    doReq(1, 3'b001, 32'h0000_0030, 16'h0003, 32'hDEAD_BEEF, "R9 sh odd");
    doReq(1, 3'b010, 32'h0000_0030, 16'h0002, 32'hDEAD_BEEF, "R9 sw mis");
    doReq(0, 3'b010, 32'h0000_0031, 16'h0000, 32'h0, "R9 lw mis");
    doReq(0, 3'b101, 32'h0000_0031, 16'h0000, 32'h0, "R9 lhu odd");
    doReq(1, 3'b011, 32'h0000_0030, 16'h0000, 32'hDEAD_BEEF, "R9 bad size");
    // R9 faulted stores left memory unchanged
    doReq(0, 3'b010, 32'h0000_0030, 16'h0000, 32'h0, "R9 lw after fault");
    // R1 negative offset
    doReq(1, 3'b000, 32'h0000_003C, 16'hFFF9, 32'h0000_0055, "R1 sb neg off");
    doReq(0, 3'b010, 32'h0000_0038, 16'hFFFC, 32'h0, "R1 lw neg off");
    idle("R10 idle");
    idle("R10 idle");
    idle("R10 idle");
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule